// File: doc/BRIEF.md
# Bus-Restarted Watchdog Timer

This block is a watchdog that a processor keeps alive through ordinary traffic on a two-wire serial bus, with no separate kick pin. It samples the clock and data lines of the bus, brings them into the local clock domain, and recognises a start condition followed later by a stop condition. Each such pair reloads the timeout counter. When the counter runs out, the block pulls its active-low watchdog output low for a fixed pulse and raises a one-cycle fault strobe. The fault strobe is meant to clear the watchdog flag in a fault status register elsewhere.

Time is counted in pulses of a slow time-base tick, so all periods are given in ticks. A 2-bit period select, held in a control register elsewhere, picks one of three timeouts or turns the watchdog off. After the low pulse ends, the counter reloads and runs again without help. Decoding of bus addresses and data bytes is left to other logic.

Top module: `bus_watchdog`

## Requirements
- R1: Both bus lines pass through a two-flop synchroniser. A start is SDA going low while SCL stays high. A stop is SDA going high while SCL stays high. SDA changes while SCL is low are neither.
- R2: The counter reloads only on a stop that comes after an earlier start. A stop with no start before it, or a start with no stop after it, leaves the countdown unchanged.
- R3: Period select codes are 2'b00 = long (LONG_TICKS), 2'b01 = medium (MID_TICKS), 2'b10 = short (SHORT_TICKS) and 2'b11 = off. After a reload, wdo_n_o goes low on the tick that completes the selected number of ticks.
- R4: wdo_n_o stays low for MID_TICKS ticks under codes 00 and 01, and for SHORT_TICKS ticks under code 10. It then returns high and the full period counts again.
- R5: fault_o is high for exactly one clock cycle, and that is the cycle in which wdo_n_o first goes low.
- R6: Under code 11, wdo_n_o stays high, fault_o stays low and the counter is held at zero. Selecting a period afterwards starts a full count.
- R7: A change of the period select reloads the counter one clock later with the new period. If this happens during a low pulse, the pulse ends.
- R8: A restart that lands in the same cycle as the expiring tick wins, so no low pulse occurs. A restart that arrives while wdo_n_o is low is ignored.
- R9: After reset, wdo_n_o is high, fault_o is low and the block behaves as if the select were 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line (asynchronous) |
| sda_i | input | 1 | Sampled bus data line (asynchronous) |
| tick_i | input | 1 | One-cycle time-base pulse that paces the countdown |
| period_sel_i | input | 2 | Period select: 00 long, 01 medium, 10 short, 11 off |
| wdo_n_o | output | 1 | Active-low watchdog output |
| fault_o | output | 1 | One-cycle strobe on expiry, used to clear the watchdog fault flag |

## Verification
Two events can fall in the same cycle: a restart from the bus, and the time-base tick that would otherwise end the period. The bench counts ticks until the counter holds one. It then times a stop edge so that the detected restart reaches the counter on the same clock edge as that last tick. The result is judged at the ports: wdo_n_o must stay high, no fault strobe may appear, and the next expiry must arrive exactly one full period after that coinciding tick. The bench also checks the reverse case, a restart during the low pulse, which must neither shorten nor extend the pulse.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_BARK = 2'd2
    } wd_state_e;

    localparam logic [1:0] SEL_LONG  = 2'b00;
    localparam logic [1:0] SEL_MID   = 2'b01;
    localparam logic [1:0] SEL_SHORT = 2'b10;
    localparam logic [1:0] SEL_OFF   = 2'b11;

endpackage

// File: rtl/bwd_sync.sv
module bwd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    // Bus lines idle high, so every stage resets to one.
    logic [STAGES-1:0][WIDTH-1:0] stage_q;
    logic [STAGES-1:0][WIDTH-1:0] stage_d;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/bwd_restart_det.sv
module bwd_restart_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic restart_o
);
    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
        logic armed;
        logic restart;
    } det_t;

    det_t q, d;
    logic scl_high, start_seen, stop_seen;

    always_comb begin
        scl_high   = scl_s && q.scl_prev;
        start_seen = scl_high && q.sda_prev && !sda_s;
        stop_seen  = scl_high && !q.sda_prev && sda_s;

        d          = q;
        d.scl_prev = scl_s;
        d.sda_prev = sda_s;
        d.restart  = 1'b0;
        if (start_seen) begin
            d.armed = 1'b1;
        end else if (stop_seen && q.armed) begin
            d.armed   = 1'b0;
            d.restart = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl_prev: 1'b1, sda_prev: 1'b1, armed: 1'b0, restart: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign restart_o = q.restart;

    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> !restart_o); // R2

    AST_RESTART_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> $past(q.armed)); // R2

endmodule

// File: rtl/bwd_timer.sv
module bwd_timer
    import bwd_pkg::*;
#(
    parameter int LONG_TICKS  = 1400,
    parameter int MID_TICKS   = 200,
    parameter int SHORT_TICKS = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       restart_i,
    input  logic [1:0] sel_i,
    output logic       wdo_n_o,
    output logic       fault_o
);
    localparam int CW = $clog2(LONG_TICKS + 1);

    typedef struct packed {
        wd_state_e     state;
        logic [CW-1:0] cnt;
        logic [1:0]    sel;
        logic          fault;
    } tmr_t;

    tmr_t q, d;
    logic [CW-1:0] period, pulse;

    always_comb begin
        unique case (sel_i)
            SEL_LONG:  period = CW'(LONG_TICKS);
            SEL_MID:   period = CW'(MID_TICKS);
            SEL_SHORT: period = CW'(SHORT_TICKS);
            default:   period = '0;
        endcase
        pulse = (q.sel == SEL_SHORT) ? CW'(SHORT_TICKS) : CW'(MID_TICKS);

        d       = q;
        d.sel   = sel_i;
        d.fault = 1'b0;

        if (sel_i == SEL_OFF) begin
            d.state = WD_OFF;
            d.cnt   = '0;
        end else if (sel_i != q.sel) begin
            d.state = WD_RUN;
            d.cnt   = period;
        end else begin
            unique case (q.state)
                WD_RUN: begin
                    if (restart_i) begin
                        d.cnt = period;
                    end else if (tick_i) begin
                        if (q.cnt <= CW'(1)) begin
                            d.state = WD_BARK;
                            d.cnt   = pulse;
                            d.fault = 1'b1;
                        end else begin
                            d.cnt = q.cnt - CW'(1);
                        end
                    end
                end
                WD_BARK: begin
                    if (tick_i) begin
                        if (q.cnt <= CW'(1)) begin
                            d.state = WD_RUN;
                            d.cnt   = period;
                        end else begin
                            d.cnt = q.cnt - CW'(1);
                        end
                    end
                end
                default: begin
                    d.state = WD_RUN;
                    d.cnt   = period;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: WD_OFF, cnt: '0, sel: SEL_OFF, fault: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign wdo_n_o = (q.state != WD_BARK);
    assign fault_o = q.fault;

    AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o); // R5

    AST_FAULT_AT_BARK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdo_n_o) |-> fault_o); // R5

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SEL_OFF) |=> (wdo_n_o && !fault_o && q.cnt == '0)); // R6

    AST_SEL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i != q.sel && sel_i != SEL_OFF) |=> (wdo_n_o && q.cnt == $past(period))); // R7

    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && q.state == WD_RUN) |=> (wdo_n_o && !fault_o)); // R8

    AST_BARK_IGNORES_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == WD_BARK && restart_i && !tick_i && sel_i == q.sel) |=> !wdo_n_o); // R8

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
    import bwd_pkg::*;
#(
    parameter int LONG_TICKS  = 1400,
    parameter int MID_TICKS   = 200,
    parameter int SHORT_TICKS = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       tick_i,
    input  logic [1:0] period_sel_i,
    output logic       wdo_n_o,
    output logic       fault_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] lines_s;
    logic             restart;

    bwd_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (lines_s)
    );

    bwd_restart_det i_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (lines_s[1]),
        .sda_s     (lines_s[0]),
        .restart_o (restart)
    );

    bwd_timer #(
        .LONG_TICKS  (LONG_TICKS),
        .MID_TICKS   (MID_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .restart_i (restart),
        .sel_i     (period_sel_i),
        .wdo_n_o   (wdo_n_o),
        .fault_o   (fault_o)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        $rose(rst_n) |-> (wdo_n_o && !fault_o)); // R9

endmodule

// File: tb/test_bus_watchdog.sv
module test_bus_watchdog;
    localparam int LONG  = 40;
    localparam int MID   = 20;
    localparam int SHORT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] sel = 2'b11;
    logic       wdo_n, fault;

    int checks = 0;
    int fails  = 0;
    int tick_no = 0;
    int exp_q[$];
    int k;

    always #5 clk = ~clk;

    bus_watchdog #(
        .LONG_TICKS  (LONG),
        .MID_TICKS   (MID),
        .SHORT_TICKS (SHORT)
    ) i_bus_watchdog (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda),
        .tick_i       (tick),
        .period_sel_i (sel),
        .wdo_n_o      (wdo_n),
        .fault_o      (fault)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (tick %0d)", req, act, exp, tick_no);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1; tick_no++;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_sel(input logic [1:0] v);
        @(negedge clk); sel = v;
        hold(2);
    endtask

    // start, SCL low, SDA stays low, SCL high, stop
    task automatic bus_restart();
        @(negedge clk); sda = 1'b0; hold(4);
        scl = 1'b0; hold(4);
        scl = 1'b1; hold(4);
        sda = 1'b1; hold(6);
    endtask

    task automatic stop_only();
        @(negedge clk); scl = 1'b0; hold(4);
        sda = 1'b0; hold(4);
        scl = 1'b1; hold(4);
        sda = 1'b1; hold(6);
    endtask

    task automatic start_only();
        @(negedge clk); sda = 1'b0; hold(4);
        scl = 1'b0; hold(4);
        sda = 1'b1; hold(4);
        scl = 1'b1; hold(6);
    endtask

    // monitor: each fault strobe must match the next expected tick number
    always @(negedge clk) begin
        if (rst_n && fault) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R5: actual fault at tick %0d expected none", tick_no);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != tick_no) begin
                    fails++;
                    $display("FAIL R3 R4: actual fault at tick %0d expected tick %0d", tick_no, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        hold(3);
        chk("R9 wdo in reset", wdo_n, 1'b1);
        chk("R9 fault in reset", fault, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        hold(2);
        chk("R9 wdo after reset", wdo_n, 1'b1);

        tick_n(30);
        chk("R6 off keeps wdo high", wdo_n, 1'b1);

        // short period, automatic re-arm, restart during bark ignored
        set_sel(2'b10);
        k = tick_no;
        exp_q.push_back(k + SHORT);
        tick_n(SHORT - 1);
        chk("R3 short not yet expired", wdo_n, 1'b1);
        tick_n(1);
        chk("R3 short expired", wdo_n, 1'b0);
        bus_restart();
        chk("R8 restart in bark ignored", wdo_n, 1'b0);
        tick_n(SHORT - 1);
        chk("R4 short pulse still low", wdo_n, 1'b0);
        tick_n(1);
        chk("R4 short pulse ended", wdo_n, 1'b1);
        exp_q.push_back(k + 3 * SHORT);
        tick_n(SHORT);
        chk("R4 re-armed short expires", wdo_n, 1'b0);

        // select change during bark ends it
        set_sel(2'b01);
        chk("R7 sel change ends bark", wdo_n, 1'b1);

        // bus restarts keep it alive
        tick_n(MID - 5);
        bus_restart();
        tick_n(MID - 5);
        bus_restart();
        k = tick_no;
        tick_n(MID - 1);
        chk("R1 R2 start+stop restarts", wdo_n, 1'b1);
        exp_q.push_back(k + MID);
        tick_n(1);
        chk("R3 medium expired", wdo_n, 1'b0);
        tick_n(MID);
        chk("R4 medium pulse ended", wdo_n, 1'b1);

        // stop with no start before it
        k = tick_no;
        tick_n(MID - 5);
        stop_only();
        exp_q.push_back(k + MID);
        tick_n(5);
        chk("R2 stop alone no restart", wdo_n, 1'b0);
        tick_n(MID);

        // start with no stop after it (SDA change with SCL low is no stop, R1)
        k = tick_no;
        tick_n(MID - 5);
        start_only();
        exp_q.push_back(k + MID);
        tick_n(5);
        chk("R2 start alone no restart", wdo_n, 1'b0);
        tick_n(MID);

        // restart lands on the expiring tick (detector already armed)
        tick_n(MID - 1);
        @(negedge clk); scl = 1'b0; hold(4);
        sda = 1'b0; hold(4);
        scl = 1'b1; hold(4);
        sda = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); tick = 1'b1; tick_no++;
        @(negedge clk); tick = 1'b0;
        chk("R8 restart beats expiry", wdo_n, 1'b1);
        k = tick_no;
        exp_q.push_back(k + MID);
        tick_n(MID);
        chk("R8 full period after tie", wdo_n, 1'b0);
        tick_n(MID);

        // disable then long period
        set_sel(2'b11);
        chk("R6 disable forces high", wdo_n, 1'b1);
        tick_n(50);
        chk("R6 disabled stays high", wdo_n, 1'b1);
        set_sel(2'b00);
        k = tick_no;
        exp_q.push_back(k + LONG);
        tick_n(LONG - 1);
        chk("R6 R3 long full count", wdo_n, 1'b1);
        tick_n(1);
        chk("R3 long expired", wdo_n, 1'b0);
        tick_n(MID - 1);
        chk("R4 long pulse uses medium width", wdo_n, 1'b0);
        tick_n(1);
        chk("R4 long pulse ended", wdo_n, 1'b1);

        hold(4);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R5: actual %0d faults missing expected 0", exp_q.size());
        end
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule